// File: doc/BRIEF.md
# Hardware Task Slot Sequencer

This block decides which of four hardware tasks may issue an instruction on each clock cycle. Software loads a 32-bit slot pattern made of sixteen 2-bit task numbers. The sequencer walks through the active slots of that pattern and presents the task number of the current slot. Slots that hold zero at the top end of the pattern are not part of the rotation, so a short pattern gives a short loop.

The block also handles instructions that must wait. The issue stage reports that the instruction it holds cannot complete yet. With a non-zero pattern loaded, the block is in multitask mode. It then leaves the pipeline running and sends out a redirect. The redirect points back at the waiting instruction's own address and is tagged with that instruction's task number, so that the task retries while the other tasks keep flowing. With an all-zero pattern the block is in single-task mode and asserts a pipeline stall instead.

Top module: `task_slot_seq`

## Requirements
- R1: After reset, `multi_mode` is 0 and `cur_tid` is 0. While `wait_req` is 0, both `stall` and `redir_valid` are 0.
- R2: On the cycle after a load (`pat_load`=1 at a rising edge), `multi_mode` equals the OR of all 32 bits of the loaded pattern. It keeps that value until the next load.
- R3: Slot k of the pattern occupies bits [2k+1:2k], and slot 0 sits at the least significant end. On the n-th cycle after a load (n = 0 is the first cycle after the load edge), `cur_tid` shows slot n mod L.
- R4: The loop length L is 16 minus the number of consecutive all-zero slots counted down from slot 15, with a minimum of 1. After slot L-1 the rotation returns to slot 0.
- R5: A load made in the middle of a rotation restarts the rotation at slot 0 of the new pattern on the next cycle.
- R6: In single-task mode (`multi_mode`=0), `wait_req`=1 asserts `stall` in the same cycle, and `redir_valid` stays 0.
- R7: In multitask mode, `wait_req`=1 asserts `redir_valid` in the same cycle, and `stall` stays 0. `redir_addr` equals `wait_addr` and `redir_tid` equals `wait_tid`.
- R8: `stall` and `redir_valid` are never 1 in the same cycle.
- R9: While an all-zero pattern is loaded, `cur_tid` is 0 on every cycle.
- R10: Zero slots that lie below the highest non-zero slot stay in the rotation as task-0 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_load | input | 1 | Load `pat_data` as the new slot pattern |
| pat_data | input | 32 | Slot pattern: sixteen 2-bit task numbers |
| wait_req | input | 1 | The issuing instruction's wait condition is not met |
| wait_tid | input | 2 | Task number of the waiting instruction |
| wait_addr | input | 16 | Address of the waiting instruction |
| cur_tid | output | 2 | Task number granted the current issue slot |
| multi_mode | output | 1 | Multitask mode flag |
| stall | output | 1 | Hold the pipeline (single-task wait) |
| redir_valid | output | 1 | Re-issue request (multitask wait) |
| redir_tid | output | 2 | Task whose program counter is rewound |
| redir_addr | output | 16 | Address to re-issue |

## Verification
A load takes effect at the next rising edge. On the cycle after that edge, `multi_mode` shows the new mode and `cur_tid` shows slot 0. Each later edge moves one slot, so the bench drives inputs at the falling edge and reads the slot n result n falling edges after the load. `stall` and the redirect outputs are combinational from the wait inputs and the registered mode, so the bench checks them shortly after driving the wait inputs, within the same cycle and before the next edge.

// File: rtl/task_seq_pkg.sv
package task_seq_pkg;
    localparam int NUM_TASKS = 4;
    localparam int TID_W     = $clog2(NUM_TASKS);
    localparam int SLOTS     = 16;
    localparam int PAT_W     = SLOTS * TID_W;
    localparam int LEN_W     = $clog2(SLOTS + 1);
    localparam int PTR_W     = $clog2(SLOTS);
    localparam int ADDR_W    = 16;

    typedef logic [TID_W-1:0]  tid_t;
    typedef logic [PAT_W-1:0]  pattern_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic              valid;
        tid_t              tid;
        logic [ADDR_W-1:0] addr;
    } issue_t;

    // Active rotation length: one past the highest non-zero slot, minimum 1.
    function automatic len_t active_len(input pattern_t p);
        int top;
        top = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (p[i*TID_W +: TID_W] != '0) top = i + 1;
        end
        if (top == 0) top = 1;
        return top[LEN_W-1:0];
    endfunction
endpackage

// File: rtl/slot_pattern_reg.sv
module slot_pattern_reg
    import task_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pattern_t data,
    output pattern_t pattern,
    output logic     multi,
    output len_t     loop_len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pattern  <= '0;
            multi    <= 1'b0;
            loop_len <= len_t'(1);
        end else if (load) begin
            pattern  <= data;
            multi    <= |data;
            loop_len <= active_len(data);
        end
    end

    AST_MODE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (multi == $past(|data)));  // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(multi));  // R2
endmodule

// File: rtl/slot_pointer.sv
module slot_pointer
    import task_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  len_t loop_len,
    output ptr_t ptr
);
    logic [LEN_W-1:0] ptr_inc;
    assign ptr_inc = LEN_W'(ptr) + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ptr <= '0;
        end else if (ptr_inc >= loop_len) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + ptr_t'(1);
        end
    end

    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ptr == '0));  // R5
endmodule

// File: rtl/wait_handler.sv
module wait_handler
    import task_seq_pkg::*;
(
    input  logic   multi,
    input  issue_t waiting,
    output logic   stall,
    output issue_t redirect
);
    always_comb begin
        stall          = waiting.valid & ~multi;
        redirect.valid = waiting.valid & multi;
        redirect.tid   = waiting.tid;
        redirect.addr  = waiting.addr;
    end
endmodule

// File: rtl/task_slot_seq.sv
module task_slot_seq
    import task_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pat_load,
    input  logic [PAT_W-1:0]  pat_data,
    input  logic              wait_req,
    input  logic [TID_W-1:0]  wait_tid,
    input  logic [ADDR_W-1:0] wait_addr,
    output logic [TID_W-1:0]  cur_tid,
    output logic              multi_mode,
    output logic              stall,
    output logic              redir_valid,
    output logic [TID_W-1:0]  redir_tid,
    output logic [ADDR_W-1:0] redir_addr
);
    pattern_t pattern;
    len_t     loop_len;
    ptr_t     ptr;
    issue_t   waiting;
    issue_t   redirect;
    tid_t     slot_tid [SLOTS];

    slot_pattern_reg u_pat (
        .clk      (clk),
        .rst      (rst),
        .load     (pat_load),
        .data     (pat_data),
        .pattern  (pattern),
        .multi    (multi_mode),
        .loop_len (loop_len)
    );

    slot_pointer u_ptr (
        .clk      (clk),
        .rst      (rst),
        .restart  (pat_load),
        .loop_len (loop_len),
        .ptr      (ptr)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_tid[s] = pattern[s*TID_W +: TID_W];
    end

    assign cur_tid = slot_tid[ptr];

    assign waiting.valid = wait_req;
    assign waiting.tid   = wait_tid;
    assign waiting.addr  = wait_addr;

    wait_handler u_wait (
        .multi    (multi_mode),
        .waiting  (waiting),
        .stall    (stall),
        .redirect (redirect)
    );

    assign redir_valid = redirect.valid;
    assign redir_tid   = redirect.tid;
    assign redir_addr  = redirect.addr;

    AST_PTR_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
        (LEN_W'(ptr) < loop_len));  // R4
    AST_STALL_REDIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stall && redir_valid));  // R8
    AST_STALL_ONLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stall |-> !multi_mode);  // R6
    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (multi_mode && redir_addr == wait_addr && redir_tid == wait_tid));  // R7
    AST_SINGLE_TID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !multi_mode |-> (cur_tid == '0));  // R9
endmodule

// File: tb/task_slot_seq_tb_top.sv
module task_slot_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        pat_load;
    logic [31:0] pat_data;
    logic        wait_req;
    logic [1:0]  wait_tid;
    logic [15:0] wait_addr;
    logic [1:0]  cur_tid;
    logic        multi_mode;
    logic        stall;
    logic        redir_valid;
    logic [1:0]  redir_tid;
    logic [15:0] redir_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    task_slot_seq dut_i (
        .clk(clk), .rst(rst), .pat_load(pat_load), .pat_data(pat_data),
        .wait_req(wait_req), .wait_tid(wait_tid), .wait_addr(wait_addr),
        .cur_tid(cur_tid), .multi_mode(multi_mode), .stall(stall),
        .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_addr(redir_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [31:0] p);
        int n = 16;
        while (n > 1 && p[2*(n-1) +: 2] == 2'b00) n--;
        return n;
    endfunction

    // Returns at the falling edge that follows the load edge (slot 0 visible).
    task automatic load_pat(input logic [31:0] p);
        @(negedge clk);
        pat_load = 1'b1;
        pat_data = p;
        @(negedge clk);
        pat_load = 1'b0;
    endtask

    task automatic walk(input string req, input logic [31:0] p, input int n);
        int len = exp_len(p);
        for (int k = 0; k < n; k++) begin
            chk(req, {30'd0, cur_tid}, {30'd0, p[2*(k % len) +: 2]});
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 multi_mode", {31'd0, multi_mode}, 0);
        chk("R1 cur_tid", {30'd0, cur_tid}, 0);
        chk("R1 stall", {31'd0, stall}, 0);
        chk("R1 redir_valid", {31'd0, redir_valid}, 0);
    endtask

    task automatic t_all_zero;
        load_pat(32'h0);
        chk("R2 zero pattern mode", {31'd0, multi_mode}, 0);
        for (int k = 0; k < 20; k++) begin
            chk("R9 tid fixed 0", {30'd0, cur_tid}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_full;
        load_pat(32'hE41B_6C93);
        chk("R2 full pattern mode", {31'd0, multi_mode}, 1);
        walk("R3 full rotation", 32'hE41B_6C93, 40);
    endtask

    task automatic t_short;
        load_pat(32'h0000_0039);
        walk("R4 leading zeros shorten loop", 32'h0000_0039, 12);
    endtask

    task automatic t_interior;
        load_pat(32'h0000_0C06);
        walk("R10 interior zero slots kept", 32'h0000_0C06, 18);
    endtask

    task automatic t_min;
        load_pat(32'h0000_0001);
        chk("R2 single slot mode", {31'd0, multi_mode}, 1);
        walk("R4 minimum length 1", 32'h0000_0001, 6);
    endtask

    task automatic t_reload;
        load_pat(32'h0000_00E4);
        chk("R3 slot0 before reload", {30'd0, cur_tid}, 0);
        @(negedge clk);
        chk("R3 slot1 before reload", {30'd0, cur_tid}, 1);
        pat_load = 1'b1;
        pat_data = 32'h0000_0036;
        @(negedge clk);
        pat_load = 1'b0;
        chk("R5 restart at slot 0", {30'd0, cur_tid}, 2);
        @(negedge clk);
        chk("R5 then slot 1", {30'd0, cur_tid}, 1);
    endtask

    task automatic t_wait_single;
        load_pat(32'h0);
        wait_req = 1'b1; wait_tid = 2'd0; wait_addr = 16'h1234;
        #1;
        chk("R6 stall asserted", {31'd0, stall}, 1);
        chk("R6 no redirect", {31'd0, redir_valid}, 0);
        @(negedge clk);
        wait_req = 1'b0;
        #1;
        chk("R6 stall released", {31'd0, stall}, 0);
    endtask

    task automatic t_wait_multi;
        load_pat(32'h0000_00E4);
        wait_req = 1'b1; wait_tid = 2'd3; wait_addr = 16'hBEEF;
        #1;
        chk("R7 redirect asserted", {31'd0, redir_valid}, 1);
        chk("R7 redirect addr", {16'd0, redir_addr}, 32'hBEEF);
        chk("R7 redirect tid", {30'd0, redir_tid}, 3);
        chk("R8 no stall with redirect", {31'd0, stall}, 0);
        @(negedge clk);
        wait_tid = 2'd1; wait_addr = 16'h0042;
        #1;
        chk("R7 redirect addr 2", {16'd0, redir_addr}, 32'h0042);
        chk("R7 redirect tid 2", {30'd0, redir_tid}, 1);
        @(negedge clk);
        wait_req = 1'b0;
        #1;
        chk("R7 redirect released", {31'd0, redir_valid}, 0);
    endtask

    initial begin
        rst = 1'b1; pat_load = 1'b0; pat_data = '0;
        wait_req = 1'b0; wait_tid = '0; wait_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_zero();
        t_full();
        t_short();
        t_interior();
        t_min();
        t_reload();
        t_wait_single();
        t_wait_multi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule